// File: doc/BRIEF.md
# Truncated Carry-Save Array Multiplier

This block multiplies an unsigned multiplicand by an unsigned multiplier in one combinational pass. It builds the product with a carry-save cell array and finishes it with a ripple-carry merge adder. Two elaboration-time parameters remove part of the cell array on purpose. This gives up accuracy in exchange for fewer cells and a shorter carry path. The full adders in the rows pass the carry-save sum and carry vectors down the array. The low product bits leave the array one per row. The merge adder then turns the last row's sum and carry vectors into the upper half of the product.

The row cut parameter removes every cell that belongs to the lowest multiplier bits. The column cut parameter removes every cell whose binary weight falls below a threshold. A removed cell drives zero on both its sum and its carry outputs. With both parameters at zero the block is an exact multiplier. Any other setting gives a result that can only be smaller than the true product. The block suits datapaths such as neural accumulators and defuzzifiers that tolerate a small, one-sided error.

Top module: `brk_array_mul`

## Requirements
- R1: Let multiplier bit i select row i and multiplicand bit j select cell j, so that the cell has weight i+j. A cell is kept when i >= ROW_CUT and i+j >= COL_CUT. The product equals the sum of 2^(i+j) over every kept cell whose operand bits are both 1.
- R2: With ROW_CUT = 0 and COL_CUT = 0 the product equals the exact product mcand*mplier for every operand pair.
- R3: For any parameter setting the product is never larger than mcand*mplier.
- R4: Product bits below position max(ROW_CUT, COL_CUT) are always 0.
- R5: Multiplier bits in positions below ROW_CUT have no effect on the product.
- R6: A zero multiplicand, or a multiplier whose bits at ROW_CUT and above are all 0, gives a zero product.
- R7: With both operands all ones, the product equals the number of kept cells, each weighted by 2^(i+j), summed without loss in the merge adder.
- R8: The product follows an operand change without any clock. The new value is present before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | MCAND_W | Unsigned multiplicand; bit j feeds cell j of every row |
| mplier | input | MPLIER_W | Unsigned multiplier; bit i enables row i |
| product | output | MCAND_W+MPLIER_W | Approximate unsigned product |

## Verification
The row cut and the column cut can remove the same cells. These are the corner cells that lie both in a low row and in a low column. Those cells must count once, as zero, while carries from the kept cells next to them still pass into the merge adder in the same evaluation. Two configurations provoke this: an 8x8 instance with both cuts set and a 6x5 instance with both cuts set. Each is driven with all-ones operands, walking single bits and pseudo-random pairs. Every output is judged against a behavioural sum of the kept partial products, and against the exact product as an upper bound.

// File: rtl/brk_mul_pkg.sv
package brk_mul_pkg;
   // A cell at row r (multiplier bit) and column c (multiplicand bit) survives
   // when it lies on or below the row cut and its weight reaches the column cut.
   function automatic bit cell_kept(input int r, input int c, input int row_cut, input int col_cut);
      return (r >= row_cut) && ((r + c) >= col_cut);
   endfunction

   // Lowest product position that any kept cell can reach.
   function automatic int zero_floor(input int row_cut, input int col_cut);
      return (row_cut > col_cut) ? row_cut : col_cut;
   endfunction
endpackage

// File: rtl/brk_and_cell.sv
module brk_and_cell (
   input  logic mcand_bit,
   input  logic mplier_bit,
   output logic sum_out
);
   timeunit 1ns; timeprecision 1ps;
   // Head of the array: nothing arrives from above, so the cell is a bare AND.
   assign sum_out = mcand_bit & mplier_bit;
endmodule

// File: rtl/brk_fa_cell.sv
module brk_fa_cell (
   input  logic mcand_bit,
   input  logic mplier_bit,
   input  logic sum_in,
   input  logic carry_in,
   output logic sum_out,
   output logic carry_out
);
   timeunit 1ns; timeprecision 1ps;
   logic pp;
   assign pp        = mcand_bit & mplier_bit;
   assign sum_out   = pp ^ sum_in ^ carry_in;
   assign carry_out = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);
endmodule

// File: rtl/brk_ripple_merge.sv
module brk_ripple_merge #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] s
);
   timeunit 1ns; timeprecision 1ps;
   logic [W-1:0] cy;
   assign cy[0] = 1'b0;
   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s[k] = x[k] ^ y[k] ^ cy[k];
      // The top stage drives no carry: the product width already bounds the sum.
      if (k < W - 1) begin : g_cy
         assign cy[k+1] = (x[k] & y[k]) | (x[k] & cy[k]) | (y[k] & cy[k]);
      end
   end
endmodule

// File: rtl/brk_csa_array.sv
module brk_csa_array
   import brk_mul_pkg::*;
#(
   parameter int M       = 8,
   parameter int N       = 8,
   parameter int ROW_CUT = 0,
   parameter int COL_CUT = 0
) (
   input  logic [M-1:0] mcand,
   input  logic [N-1:0] mplier,
   output logic [N-1:0] low_bits,
   output logic [M-1:0] sum_vec,
   output logic [M-1:0] carry_vec
);
   timeunit 1ns; timeprecision 1ps;
   // Row r: sum bit c has weight r+c, carry bit c has weight r+c+1.
   logic [M-1:0] row_sum   [N];
   logic [M-1:0] row_carry [N];

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < M; c++) begin : g_col
         localparam bit KEEP  = cell_kept(r, c, ROW_CUT, COL_CUT);
         localparam bit FIRST = (r == ROW_CUT);
         if (!KEEP) begin : g_cut
            assign row_sum[r][c]   = 1'b0;
            assign row_carry[r][c] = 1'b0;
         end else if (FIRST) begin : g_head
            brk_and_cell i_cell (
               .mcand_bit (mcand[c]),
               .mplier_bit(mplier[r]),
               .sum_out   (row_sum[r][c])
            );
            assign row_carry[r][c] = 1'b0;
         end else begin : g_body
            logic sin;
            if (c < M - 1) begin : g_mid
               assign sin = row_sum[r-1][c+1];
            end else begin : g_edge
               assign sin = 1'b0;
            end
            brk_fa_cell i_cell (
               .mcand_bit (mcand[c]),
               .mplier_bit(mplier[r]),
               .sum_in    (sin),
               .carry_in  (row_carry[r-1][c]),
               .sum_out   (row_sum[r][c]),
               .carry_out (row_carry[r][c])
            );
         end
      end
      assign low_bits[r] = row_sum[r][0];
   end

   assign sum_vec   = {1'b0, row_sum[N-1][M-1:1]};
   assign carry_vec = row_carry[N-1];
endmodule

// File: rtl/brk_array_mul.sv
module brk_array_mul #(
   parameter int MCAND_W  = 8,
   parameter int MPLIER_W = 8,
   parameter int ROW_CUT  = 0,
   parameter int COL_CUT  = 0
) (
   input  logic [MCAND_W-1:0]          mcand,
   input  logic [MPLIER_W-1:0]         mplier,
   output logic [MCAND_W+MPLIER_W-1:0] product
);
   timeunit 1ns; timeprecision 1ps;
   localparam int PROD_W = MCAND_W + MPLIER_W;

   if (MCAND_W < 2 || MPLIER_W < 2) begin : g_bad_width
      $error("brk_array_mul: operand widths must be at least 2");
   end
   if (ROW_CUT < 0 || ROW_CUT >= MPLIER_W) begin : g_bad_row
      $error("brk_array_mul: ROW_CUT must lie in [0, MPLIER_W)");
   end
   if (COL_CUT < 0 || COL_CUT >= MPLIER_W) begin : g_bad_col
      $error("brk_array_mul: COL_CUT must lie in [0, MPLIER_W)");
   end

   logic [MPLIER_W-1:0] low_bits;
   logic [MCAND_W-1:0]  sum_vec;
   logic [MCAND_W-1:0]  carry_vec;
   logic [MCAND_W-1:0]  high_bits;

   brk_csa_array #(
      .M(MCAND_W), .N(MPLIER_W), .ROW_CUT(ROW_CUT), .COL_CUT(COL_CUT)
   ) i_array (
      .mcand    (mcand),
      .mplier   (mplier),
      .low_bits (low_bits),
      .sum_vec  (sum_vec),
      .carry_vec(carry_vec)
   );

   brk_ripple_merge #(.W(MCAND_W)) i_merge (
      .x(sum_vec),
      .y(carry_vec),
      .s(high_bits)
   );

   assign product = PROD_W'({high_bits, low_bits});
endmodule

// File: rtl/brk_array_mul_chk.sv
module brk_array_mul_chk
   import brk_mul_pkg::*;
#(
   parameter int MCAND_W  = 8,
   parameter int MPLIER_W = 8,
   parameter int ROW_CUT  = 0,
   parameter int COL_CUT  = 0
) (
   input logic [MCAND_W-1:0]          mcand,
   input logic [MPLIER_W-1:0]         mplier,
   input logic [MCAND_W+MPLIER_W-1:0] product
);
   timeunit 1ns; timeprecision 1ps;
   localparam int PW    = MCAND_W + MPLIER_W;
   localparam int FLOOR = zero_floor(ROW_CUT, COL_CUT);
   localparam logic [PW-1:0] LOW_MASK = (PW'(1) << FLOOR) - PW'(1);

   logic [PW-1:0] exact;
   assign exact = PW'(mcand) * PW'(mplier);

   always_comb begin
      assert_no_overshoot_R3: assert (product <= exact)
         else $error("R3: product %0d exceeds exact %0d", product, exact);
      assert_low_clear_R4: assert ((product & LOW_MASK) == '0)
         else $error("R4: low bits set in %0h", product);
      assert_zero_operand_R6: assert (!(mcand == '0 || (mplier >> ROW_CUT) == '0) || product == '0)
         else $error("R6: nonzero product %0d from zero operand", product);
   end

   if (ROW_CUT == 0 && COL_CUT == 0) begin : g_exact
      always_comb begin
         assert_exact_R2: assert (product == exact)
            else $error("R2: product %0d differs from exact %0d", product, exact);
      end
   end
endmodule

bind brk_array_mul brk_array_mul_chk #(
   .MCAND_W(MCAND_W), .MPLIER_W(MPLIER_W), .ROW_CUT(ROW_CUT), .COL_CUT(COL_CUT)
) i_chk (
   .mcand  (mcand),
   .mplier (mplier),
   .product(product)
);

// File: tb/test_brk_array_mul.sv
module test_brk_array_mul;
   timeunit 1ns; timeprecision 1ps;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2ns clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0]  a8 = '0, b8 = '0;
   logic [5:0]  a6 = '0;
   logic [4:0]  b5 = '0;
   logic [15:0] p_cut, p_ex;
   logic [10:0] p_odd;

   brk_array_mul #(.MCAND_W(8), .MPLIER_W(8), .ROW_CUT(2), .COL_CUT(3)) i_brk_array_mul (
      .mcand(a8), .mplier(b8), .product(p_cut));
   brk_array_mul #(.MCAND_W(8), .MPLIER_W(8), .ROW_CUT(0), .COL_CUT(0)) i_brk_array_mul_exact (
      .mcand(a8), .mplier(b8), .product(p_ex));
   brk_array_mul #(.MCAND_W(6), .MPLIER_W(5), .ROW_CUT(3), .COL_CUT(4)) i_brk_array_mul_odd (
      .mcand(a6), .mplier(b5), .product(p_odd));

   function automatic longint ref_prod(longint a, longint b, int m, int n, int rc, int cc);
      longint acc = 0;
      for (int i = 0; i < n; i++)
         for (int j = 0; j < m; j++)
            if (((b >> i) & 1) == 1 && ((a >> j) & 1) == 1 && i >= rc && (i + j) >= cc)
               acc += longint'(1) << (i + j);
      return acc;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      #1ns;
      a8 = a; b8 = b; a6 = a[5:0]; b5 = b[4:0];
      @(negedge clk);
   endtask

   task automatic check_all();
      chk("R1 cut8x8",  p_cut, ref_prod(a8, b8, 8, 8, 2, 3));
      chk("R1 odd6x5",  p_odd, ref_prod(a6, b5, 6, 5, 3, 4));
      chk("R2 exact",   p_ex,  longint'(a8) * longint'(b8));
      chk("R3 cut8x8",  (p_cut <= longint'(a8) * longint'(b8)) ? 1 : 0, 1);
      chk("R3 odd6x5",  (p_odd <= longint'(a6) * longint'(b5)) ? 1 : 0, 1);
      chk("R4 cut8x8",  p_cut[2:0], 0);
      chk("R4 odd6x5",  p_odd[3:0], 0);
   endtask

   initial begin
      #400us;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr = 32'h1234_5678;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state: zero operands
      chk("R6 reset cut", p_cut, 0);
      chk("R6 reset exact", p_ex, 0);
      chk("R6 reset odd", p_odd, 0);

      // full scale
      drive(8'hFF, 8'hFF);
      chk("R7 ones cut", p_cut, ref_prod(255, 255, 8, 8, 2, 3));
      chk("R7 ones odd", p_odd, ref_prod(63, 31, 6, 5, 3, 4));
      chk("R7 ones exact", p_ex, 65025);
      check_all();

      // zero operand cases
      drive(8'h00, 8'hFF);
      chk("R6 zero mcand", p_cut, 0);
      drive(8'hFF, 8'h03);
      chk("R6 low-only mplier cut", p_cut, 0);
      chk("R6 low-only mplier odd", p_odd, 0);

      // R8: new operands seen before the next edge
      drive(8'h81, 8'hF0);
      chk("R8 settle cut", p_cut, ref_prod(8'h81, 8'hF0, 8, 8, 2, 3));

      // walking single bits: corner cells of both cuts
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++) begin
            drive(8'(1 << j), 8'(1 << i));
            check_all();
         end

      // pseudo-random pairs
      for (int k = 0; k < 400; k++) begin
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         drive(lfsr[23:16], lfsr[31:24]);
         check_all();
      end

      // R5: low multiplier bits under the row cut are ignored
      for (int k = 0; k < 20; k++) begin
         logic [15:0] keep_cut;
         logic [10:0] keep_odd;
         logic [7:0]  ra, rb;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         ra = lfsr[15:8]; rb = lfsr[31:24] | 8'h07;
         drive(ra, rb);
         keep_cut = p_cut; keep_odd = p_odd;
         drive(ra, rb & 8'hFC);
         chk("R5 cut8x8", p_cut, keep_cut);
         drive(ra, rb & 8'hF8);
         chk("R5 odd6x5", p_odd, keep_odd);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule